// File: doc/BRIEF.md
# Rate-Matched Bit-Stream Clock-Crossing Sampler

This block carries a continuous single-bit serial stream from a slow source clock into a destination clock that runs an exact integer multiple faster. The source bit is first registered on the source clock. It then crosses into the destination domain through a chain of synchronizing flops. Because the destination clock is RATIO times faster, the synchronized bit holds each source value for RATIO destination cycles. A modulo-RATIO counter decimates that repetition and keeps exactly one destination-domain sample per source bit period. That sample is presented with a one-cycle valid strobe.

Each domain has its own asynchronous active-low reset. A two-flop release synchronizer makes every reset release synchronous to its own clock. A parameter sets the value the decimation counter takes at reset. This lets the sampling instant be moved away from the edges of each source bit period. The path is for one bit only. Wider data must be qualified by a single synchronized enable bit. The block assumes the two clocks are frequency-locked at the integer ratio. It does not track phase between them.

Top module: `bitstream_rate_sampler`

## Requirements
- R1: The serial input is captured on every rising source clock edge into a launch register. While the source reset is in effect, including the two source edges its release takes, the launch register holds 0. The bits then delivered downstream are therefore 0.
- R2: The synchronizer has two destination-clock stages. A bit launched at a source edge is the synchronized value from the second rising destination edge after that source edge. It stays so until the next launched bit has passed both stages.
- R3: The decimation counter steps by one on each destination cycle out of reset and runs from 0 to RATIO-1. After RATIO-1 it returns to 0. It never holds a value of RATIO or above.
- R4: `dst_bit` changes only on the destination edge that also raises `dst_valid`. It holds its value in every other cycle.
- R5: `dst_valid` is high for exactly one destination cycle: the cycle after the counter wraps from RATIO-1 to 0. Successive strobes are exactly RATIO destination cycles apart.
- R6: Asserting the destination reset forces `dst_valid` and `dst_bit` to 0 and loads the counter with PHASE_INIT. After release, the first strobe follows the (RATIO+2-PHASE_INIT)-th rising destination edge. This count includes two edges for reset-release synchronization.
- R7: Each source bit is delivered exactly once and in order, after a fixed latency. No bit is repeated or skipped, whatever PHASE_INIT is.
- R8: The source reset acts only on the source domain. While it is asserted, the destination strobe cadence continues: exactly RATIO/RATIO strobes per RATIO destination cycles, which is 4 strobes in any 20-cycle window for RATIO=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Slow source clock |
| src_rst_n | input | 1 | Asynchronous active-low source-domain reset |
| src_bit | input | 1 | Serial input bit, one per source period |
| dst_clk | input | 1 | Fast destination clock, RATIO times the source rate |
| dst_rst_n | input | 1 | Asynchronous active-low destination-domain reset |
| dst_bit | output | 1 | Decimated sample of the synchronized bit |
| dst_valid | output | 1 | One-cycle strobe marking a new sample on dst_bit |

## Verification
The checker watches the destination domain on every cycle. It covers the counter range and step, the strobe landing on the cycle after the wrap, the single-cycle width of the strobe and its RATIO-cycle spacing, the hold of the output between strobes, and the quiet outputs under reset. Only the bench scenarios can show the end-to-end properties. It compares a known stream against the sampled values through a timing model of the launch and two-stage path, so that no bit is repeated or dropped. It also covers the reset-to-first-strobe latency for two PHASE_INIT settings, the zeros launched under source reset, and the strobe cadence that continues while the source domain is held in reset.

// File: rtl/rsamp_pkg.sv
package rsamp_pkg;

  // Width needed for a counter running 0 .. n-1 (at least one bit).
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Destination-side result of one decimation step.
  typedef struct packed {
    logic smp;
    logic vld;
  } rsamp_out_t;

endpackage

// File: rtl/rsamp_rst_sync.sv
module rsamp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] shf_q;
  logic [STAGES-1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shf_q <= '0;
    else         shf_q <= shf_d;
  end

  assign rst_n_o = shf_q[STAGES-1];
endmodule

// File: rtl/rsamp_launch.sv
module rsamp_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic q_r;
  logic q_d;

  always_comb begin
    q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/rsamp_sync_chain.sv
module rsamp_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic stg_d;
      if (g == 0) begin : g_first
        always_comb stg_d = async_in;
      end else begin : g_rest
        always_comb stg_d = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= 1'b0;
        else        stg_q[g] <= stg_d;
      end
    end
  endgenerate

  assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/rsamp_decimator.sv
module rsamp_decimator
  import rsamp_pkg::*;
#(
  parameter int RATIO      = 5,
  parameter int PHASE_INIT = 0,
  parameter int CW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_bit,
  output logic          smp_o,
  output logic          vld_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST  = CW'(RATIO - 1);
  localparam logic [CW-1:0] START = CW'(PHASE_INIT);

  logic [CW-1:0] cnt_q, cnt_d;
  rsamp_out_t    out_q, out_d;
  logic          wrap;
  logic          smp_en;

  always_comb begin
    wrap      = (cnt_q == LAST);
    cnt_d     = wrap ? '0 : cnt_q + 1'b1;
    smp_en    = wrap;
    out_d.vld = wrap;
    out_d.smp = smp_en ? sync_bit : out_q.smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= START;
      out_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign smp_o = out_q.smp;
  assign vld_o = out_q.vld;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/bitstream_rate_sampler.sv
module bitstream_rate_sampler
  import rsamp_pkg::*;
#(
  parameter int RATIO       = 5,
  parameter int PHASE_INIT  = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_bit,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_bit,
  output logic dst_valid
);
  localparam int CNT_W = cnt_width(RATIO);

  logic             src_rst_q_n;
  logic             dst_rst_q_n;
  logic             launch_bit;
  logic             synced_bit;
  logic [CNT_W-1:0] cnt_w;

  rsamp_rst_sync #(.STAGES(2)) u_src_rst (
    .clk     (src_clk),
    .arst_n  (src_rst_n),
    .rst_n_o (src_rst_q_n)
  );

  rsamp_rst_sync #(.STAGES(2)) u_dst_rst (
    .clk     (dst_clk),
    .arst_n  (dst_rst_n),
    .rst_n_o (dst_rst_q_n)
  );

  rsamp_launch u_launch (
    .clk   (src_clk),
    .rst_n (src_rst_q_n),
    .d     (src_bit),
    .q     (launch_bit)
  );

  rsamp_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (dst_clk),
    .rst_n    (dst_rst_q_n),
    .async_in (launch_bit),
    .sync_out (synced_bit)
  );

  rsamp_decimator #(
    .RATIO      (RATIO),
    .PHASE_INIT (PHASE_INIT),
    .CW         (CNT_W)
  ) u_decim (
    .clk      (dst_clk),
    .rst_n    (dst_rst_q_n),
    .sync_bit (synced_bit),
    .smp_o    (dst_bit),
    .vld_o    (dst_valid),
    .cnt_o    (cnt_w)
  );
endmodule

// File: rtl/bitstream_rate_sampler_chk.sv
module bitstream_rate_sampler_chk #(
  parameter int RATIO = 5,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vld,
  input logic          smp,
  input logic [CW-1:0] cnt
);
  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (vld) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 16'hFFFF) begin
      gap_q  <= gap_q + 16'd1;
    end
  end

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < RATIO);

  a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) != RATIO - 1) |=> (cnt == $past(cnt) + 1'b1));

  a_r5_valid_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) == RATIO - 1) |=> (vld && cnt == '0));

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

  a_r5_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && seen_q) |-> (32'(gap_q) == RATIO - 1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> $stable(smp));

  a_r6_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!vld && !smp));
endmodule

bind bitstream_rate_sampler bitstream_rate_sampler_chk #(
  .RATIO (RATIO),
  .CW    (CNT_W)
) u_chk (
  .clk   (dst_clk),
  .rst_n (dst_rst_q_n),
  .vld   (dst_valid),
  .smp   (dst_bit),
  .cnt   (cnt_w)
);

// File: tb/sim_bitstream_rate_sampler.sv
`timescale 1ns/1ps
module sim_bitstream_rate_sampler;
  localparam int RATIO = 5;
  localparam int PH1   = 2;
  localparam int NBITS = 100;
  localparam logic [47:0] STREAM_TBL = 48'hE5A3_96C1_3D7F;

  logic src_clk, dst_clk, src_rst_n, dst_rst_n, src_bit;
  logic o_bit [2];
  logic o_vld [2];

  int  errors = 0;
  int  checks = 0;
  bit  mon_on = 0;
  bit  check_vals = 1;
  bit  stream_done = 0;
  bit  done = 0;
  int  last_idx [2];
  int  gap [2];
  logic prev_bit [2];

  bitstream_rate_sampler #(.RATIO(RATIO)) u0 (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_bit(src_bit),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_bit(o_bit[0]), .dst_valid(o_vld[0]));

  bitstream_rate_sampler #(.RATIO(RATIO), .PHASE_INIT(PH1)) u1 (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_bit(src_bit),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .dst_bit(o_bit[1]), .dst_valid(o_vld[1]));

  // 100 MHz destination: rising edges at 5 + 10m ns.
  initial begin
    dst_clk = 0;
    forever #5 dst_clk = ~dst_clk;
  end

  // Source at RATIO times the period: rising edges at 3 + 50i ns.
  initial begin
    src_clk = 0;
    #3;
    forever begin
      src_clk = 1; #25;
      src_clk = 0; #25;
    end
  end

  function automatic logic bitval(input int i);
    if (i < 48) return STREAM_TBL[i];
    return logic'(((i * 7) % 5) < 2);
  endfunction

  // Launch register is still in reset for source edges 0..2 (R1).
  function automatic logic expval(input int i);
    return (i < 3) ? 1'b0 : bitval(i);
  endfunction

  task automatic check(input logic ok, input string tag,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Stimulus table walked by one loop: bit i is set up before source edge i.
  initial begin
    src_bit = bitval(0);
    for (int i = 1; i < NBITS; i++) begin
      @(negedge src_clk);
      src_bit = bitval(i);
    end
    @(negedge src_clk);
    stream_done = 1;
  end

  // Timing model: a strobe after destination edge t carries bit (t-25)/50.
  always @(negedge dst_clk) begin
    if (mon_on) begin
      for (int k = 0; k < 2; k++) begin
        gap[k]++;
        if (o_vld[k]) begin
          longint t;
          int     i;
          t = $time - 5;
          i = int'((t - 25) / 50);
          if (check_vals && t >= 25) begin
            if (i < 3)
              check(o_bit[k] == expval(i), "R1 zero while source in reset", o_bit[k], expval(i));
            else
              check(o_bit[k] == expval(i), "R2 R7 sampled bit value", o_bit[k], expval(i));
          end
          if (last_idx[k] >= 0) begin
            check(i == last_idx[k] + 1, "R7 no repeat or drop", i, last_idx[k] + 1);
            check(gap[k] == RATIO, "R5 strobe spacing", gap[k], RATIO);
          end
          last_idx[k] = i;
          gap[k] = 0;
        end else begin
          check(o_bit[k] == prev_bit[k], "R4 output holds", o_bit[k], prev_bit[k]);
        end
        prev_bit[k] = o_bit[k];
      end
    end
  end

  initial begin
    int cnt0, cnt1;
    int first [2];
    src_rst_n = 1;
    dst_rst_n = 1;
    for (int k = 0; k < 2; k++) begin
      last_idx[k] = -1; gap[k] = 0; prev_bit[k] = 0;
    end
    #1;
    src_rst_n = 0;
    dst_rst_n = 0;
    @(negedge dst_clk);
    for (int k = 0; k < 2; k++) begin
      check(o_vld[k] == 0, "R6 reset valid low", o_vld[k], 0);
      check(o_bit[k] == 0, "R6 reset bit low", o_bit[k], 0);
    end
    #2;
    dst_rst_n = 1;
    src_rst_n = 1;
    mon_on = 1;
    repeat (250) @(negedge dst_clk);

    // R8: source reset leaves the destination cadence running.
    check_vals = 0;
    src_rst_n = 0;
    cnt0 = 0; cnt1 = 0;
    repeat (20) begin
      @(negedge dst_clk);
      if (o_vld[0]) cnt0++;
      if (o_vld[1]) cnt1++;
    end
    check(cnt0 == 4, "R8 cadence u0 during source reset", cnt0, 4);
    check(cnt1 == 4, "R8 cadence u1 during source reset", cnt1, 4);
    src_rst_n = 1;
    repeat (60) @(negedge dst_clk);
    check_vals = 1;
    repeat (20) @(negedge dst_clk);

    // R6: mid-run destination reset and first-strobe latency per phase.
    mon_on = 0;
    dst_rst_n = 0;
    repeat (3) begin
      @(negedge dst_clk);
      for (int k = 0; k < 2; k++) begin
        check(o_vld[k] == 0, "R6 valid low in reset", o_vld[k], 0);
        check(o_bit[k] == 0, "R6 bit low in reset", o_bit[k], 0);
      end
    end
    dst_rst_n = 1;
    first[0] = 0; first[1] = 0;
    for (int c = 1; c <= 20; c++) begin
      @(negedge dst_clk);
      for (int k = 0; k < 2; k++)
        if (o_vld[k] && first[k] == 0) first[k] = c;
    end
    check(first[0] == RATIO + 2, "R6 first strobe PHASE_INIT=0", first[0], RATIO + 2);
    check(first[1] == RATIO + 2 - PH1, "R6 first strobe PHASE_INIT=2", first[1], RATIO + 2 - PH1);
    for (int k = 0; k < 2; k++) begin
      last_idx[k] = -1; gap[k] = 0; prev_bit[k] = o_bit[k];
    end
    mon_on = 1;

    wait (stream_done);
    mon_on = 0;
    @(negedge dst_clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule